// File: doc/BRIEF.md
# Prescaled Auto-Reload Down-Counter Timer

This block is a programmable down-counting timer. It sits on a simple register bus and holds three registers: a mode word, the live count and a reload value. Once enabled, the count drops by one on every prescaler tick. The tick rate is the bus clock divided by 1, 4, 8 or 16.

A tick that finds the count already at zero is terminal count. On terminal count the block sets a sticky status flag and raises its interrupt output for one clock. With auto-reload on, the count is refilled from the reload register and the timer keeps running. With auto-reload off, the timer stops at zero and drops its own enable bit.

A protect bit in the mode word limits every register write to accesses made with the privilege input high. A write that is refused still completes on the bus but changes nothing.

Top module: `tmr_top`

## Requirements
- R1: After reset the mode word, count, reload value and interrupt output are all zero.
- R2: Byte offset 0 holds the mode word, offset 4 the count and offset 8 the reload value. In the mode word, bits [5:4] are the rate select, bit 3 is protect, bit 2 is auto-reload, bit 1 is enable and bit 0 is the terminal-count flag. Bits above 5 read as zero and ignore writes.
- R3: Rate select values 0, 1, 2 and 3 give one decrement every 1, 4, 8 and 16 clocks. The first decrement lands on the Nth rising edge after the edge that wrote the mode word.
- R4: While enable is 0 the count holds its value.
- R5: A tick that finds the count at zero sets the flag. The interrupt is high for exactly the clock after that edge.
- R6: With auto-reload on, terminal count loads the reload value into the count and leaves enable set.
- R7: With auto-reload off, terminal count leaves the count at zero and clears enable.
- R8: Writing the mode word with bit 0 at 1 clears the flag. Writing it with bit 0 at 0 leaves the flag as it was. If a terminal count occurs in the same cycle as a clear, the flag ends up set.
- R9: Every accepted mode-word write restarts the prescaler from zero.
- R10: While protect is 1, a write with the privilege input low changes no register, the protect bit included. A write with the privilege input high is accepted.
- R11: An accepted count write takes effect at the next edge, even while the timer runs. In that cycle it takes priority over the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Byte address of the register |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| priv | input | 1 | High for a privileged access |
| rdData | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | One-clock terminal-count pulse |

## Verification
A wrong prescaler phase shows up on the count readback. The decrement then lands on the wrong edge, at most 16 clocks after a mode write, and the bench checks the count both on the edge just before each expected decrement and on the edge of it. A wrong terminal-count decision shows within one clock: on the interrupt pin, on the flag, on the enable bit and on the reloaded count. A write-protect fault shows as a changed readback after a single refused write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DIV_W = 4;
  localparam int MODE_IDX = 0;
  localparam int COUNT_IDX = 1;
  localparam int RELOAD_IDX = 2;
  localparam int FLAG_BIT = 0;
  localparam int EN_BIT = 1;
  localparam int AUTO_BIT = 2;
  localparam int PROT_BIT = 3;
  localparam int SEL_LO = 4;

  typedef struct packed {
    logic ldCount;
    logic ldReload;
    logic restart;
    logic run;
    logic autoLd;
    logic [1:0] sel;
  } tmrStrobeT;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              priv,
  input  logic              tcEvent,
  input  logic [DATA_W-1:0] countVal,
  input  logic [DATA_W-1:0] reloadVal,
  output tmrStrobeT         strobe,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [1:0] selQ;
  logic protQ, autoQ, enQ, flagQ;
  logic [IDX_W-1:0] regIdx;
  logic wrOk, modeWr, cntWr, rldWr;

  assign regIdx = addr[ADDR_W-1:2];
  assign wrOk   = wrEn && (!protQ || priv);
  assign modeWr = wrOk && (regIdx == IDX_W'(MODE_IDX));
  assign cntWr  = wrOk && (regIdx == IDX_W'(COUNT_IDX));
  assign rldWr  = wrOk && (regIdx == IDX_W'(RELOAD_IDX));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ  <= '0;
      protQ <= 1'b0;
      autoQ <= 1'b0;
      enQ   <= 1'b0;
      flagQ <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (modeWr) begin
        selQ  <= wrData[SEL_LO+1:SEL_LO];
        protQ <= wrData[PROT_BIT];
        autoQ <= wrData[AUTO_BIT];
        enQ   <= wrData[EN_BIT];
      end else if (tcEvent && !autoQ) begin
        enQ <= 1'b0;
      end
      flagQ <= tcEvent | (flagQ & ~(modeWr & wrData[FLAG_BIT]));
      irq   <= tcEvent;
    end
  end

  always_comb begin
    strobe.ldCount  = cntWr;
    strobe.ldReload = rldWr;
    strobe.restart  = modeWr;
    strobe.run      = enQ;
    strobe.autoLd   = autoQ;
    strobe.sel      = selQ;
  end

  always_comb begin
    rdData = '0;
    case (regIdx)
      IDX_W'(MODE_IDX): begin
        rdData[SEL_LO+1:SEL_LO] = selQ;
        rdData[PROT_BIT]        = protQ;
        rdData[AUTO_BIT]        = autoQ;
        rdData[EN_BIT]          = enQ;
        rdData[FLAG_BIT]        = flagQ;
      end
      IDX_W'(COUNT_IDX):  rdData = countVal;
      IDX_W'(RELOAD_IDX): rdData = reloadVal;
      default:            rdData = '0;
    endcase
  end

  // R10: a refused write leaves the mode word unchanged
  p_blocked_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && protQ && !priv && !tcEvent) |=> $stable({selQ, protQ, autoQ, enQ}));

  // R5: terminal count raises the flag and the interrupt
  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    tcEvent |=> (flagQ && irq));

  // R7: without auto-reload the timer stops itself
  p_en_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tcEvent && !autoQ && !modeWr) |=> !enQ);
endmodule

// File: rtl/tmr_dpath.sv
module tmr_dpath
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobeT         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              tcEvent,
  output logic [DATA_W-1:0] countVal,
  output logic [DATA_W-1:0] reloadVal
);
  logic [DIV_W-1:0] divCnt, divLast;
  logic tick;

  always_comb begin
    case (strobe.sel)
      2'd0:    divLast = DIV_W'(0);
      2'd1:    divLast = DIV_W'(3);
      2'd2:    divLast = DIV_W'(7);
      default: divLast = DIV_W'(15);
    endcase
  end

  assign tick    = strobe.run && (divCnt == divLast);
  assign tcEvent = tick && (countVal == '0) && !strobe.ldCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (strobe.restart || !strobe.run || tick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal  <= '0;
      reloadVal <= '0;
    end else begin
      if (strobe.ldReload) reloadVal <= wrData;
      if (strobe.ldCount) begin
        countVal <= wrData;
      end else if (tcEvent) begin
        countVal <= strobe.autoLd ? reloadVal : '0;
      end else if (tick) begin
        countVal <= countVal - 1'b1;
      end
    end
  end

  // R4: the count only moves on a tick or a write
  p_hold_without_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.ldCount && !tick) |=> $stable(countVal));

  // R7: terminal count without reload parks the count at zero
  p_no_reload_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tcEvent && !strobe.autoLd) |=> (countVal == '0));

  // R3: the prescaler never passes its selected limit
  p_div_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> (divCnt <= divLast));
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              priv,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  tmrStrobeT strobe;
  logic tcEvent;
  logic [DATA_W-1:0] countVal, reloadVal;

  tmr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .priv(priv), .tcEvent(tcEvent), .countVal(countVal),
    .reloadVal(reloadVal), .strobe(strobe), .rdData(rdData), .irq(irq)
  );

  tmr_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .tcEvent(tcEvent), .countVal(countVal), .reloadVal(reloadVal)
  );
endmodule

// File: tb/tmr_top_tb.sv
module tmr_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] addr = '0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic priv = 1'b0;
  logic [31:0] rdData;
  logic irq;
  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_top u_dut (.clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .priv(priv), .rdData(rdData), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge: drives a write for the next rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic p = 1'b0);
    addr = a; wrData = d; priv = p; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; priv = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, held;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    rd(4'h0, v); chk("R1 mode", v, 32'h0);
    rd(4'h4, v); chk("R1 count", v, 32'h0);
    rd(4'h8, v); chk("R1 reload", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2: reserved bits drop, layout readback
    @(negedge clk);
    wr(4'h0, 32'hFFFF_FFFC);
    rd(4'h0, v); chk("R2 mode layout", v, 32'h3C);
    @(negedge clk);
    wr(4'h0, 32'h0, 1'b1);
    rd(4'h0, v); chk("R2 mode cleared", v, 32'h0);

    // R3: rate sweep
    for (int s = 0; s < 4; s++) begin
      n = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 16;
      @(negedge clk);
      wr(4'h4, 32'd5);
      wr(4'h0, (s << 4) | 32'h2);
      for (int k = 1; k <= 3; k++) begin
        if (n > 1) begin
          repeat (n - 1) @(posedge clk);
          @(negedge clk);
          rd(4'h4, v); chk("R3 before tick", v, 32'(5 - (k - 1)));
        end
        @(posedge clk);
        @(negedge clk);
        rd(4'h4, v); chk("R3 on tick", v, 32'(5 - k));
      end
      @(negedge clk);
      wr(4'h0, 32'h0);
      // R4: disabled timer holds
      rd(4'h4, held);
      repeat (40) @(posedge clk);
      @(negedge clk);
      rd(4'h4, v); chk("R4 hold", v, held);
    end

    // R5 / R6: auto-reload terminal count
    @(negedge clk);
    wr(4'h8, 32'd3);
    wr(4'h4, 32'd1);
    wr(4'h0, 32'h6);
    @(posedge clk); @(negedge clk);
    rd(4'h4, v); chk("R6 reach zero", v, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R5 irq high", {31'b0, irq}, 32'h1);
    rd(4'h4, v); chk("R6 reloaded", v, 32'd3);
    rd(4'h0, v); chk("R6 still enabled, R5 flag", v, 32'h7);
    @(posedge clk); @(negedge clk);
    chk("R5 irq one clock", {31'b0, irq}, 32'h0);
    rd(4'h4, v); chk("R6 keeps running", v, 32'd2);
    // R8: write zero keeps flag, write one clears
    @(negedge clk);
    wr(4'h0, 32'h4);
    rd(4'h0, v); chk("R8 zero keeps flag", v, 32'h5);
    @(negedge clk);
    wr(4'h0, 32'h5);
    rd(4'h0, v); chk("R8 one clears flag", v, 32'h4);
    @(negedge clk);
    wr(4'h0, 32'h0);

    // R8: set wins over clear
    @(negedge clk);
    wr(4'h4, 32'd0);
    wr(4'h0, 32'h2);
    wr(4'h0, 32'h1);
    chk("R8 irq on collision", {31'b0, irq}, 32'h1);
    rd(4'h0, v); chk("R8 set wins", v, 32'h1);
    @(negedge clk);
    wr(4'h0, 32'h1);

    // R7: no reload stops at zero
    @(negedge clk);
    wr(4'h4, 32'd2);
    wr(4'h0, 32'h2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 irq", {31'b0, irq}, 32'h1);
    rd(4'h4, v); chk("R7 count zero", v, 32'd0);
    rd(4'h0, v); chk("R7 enable cleared", v, 32'h1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd(4'h4, v); chk("R7 stays zero", v, 32'd0);
    chk("R7 no further irq", {31'b0, irq}, 32'h0);
    @(negedge clk);
    wr(4'h0, 32'h1);

    // R9: prescaler restarts on mode write
    @(negedge clk);
    wr(4'h4, 32'd100);
    wr(4'h0, 32'h32);
    repeat (10) @(posedge clk);
    @(negedge clk);
    wr(4'h0, 32'h32);
    repeat (15) @(posedge clk);
    @(negedge clk);
    rd(4'h4, v); chk("R9 no early tick", v, 32'd100);
    @(posedge clk); @(negedge clk);
    rd(4'h4, v); chk("R9 tick after restart", v, 32'd99);
    @(negedge clk);
    wr(4'h0, 32'h0);

    // R10: write protection
    @(negedge clk);
    rd(4'h4, held);
    @(negedge clk);
    wr(4'h0, 32'h8);
    wr(4'h4, 32'd77);
    wr(4'h8, 32'd55);
    wr(4'h0, 32'h0);
    rd(4'h0, v); chk("R10 protect kept", v, 32'h8);
    rd(4'h4, v); chk("R10 count kept", v, held);
    rd(4'h8, v); chk("R10 reload kept", v, 32'd3);
    @(negedge clk);
    wr(4'h4, 32'd77, 1'b1);
    rd(4'h4, v); chk("R10 privileged write", v, 32'd77);
    @(negedge clk);
    wr(4'h0, 32'h0, 1'b1);
    rd(4'h0, v); chk("R10 privileged unprotect", v, 32'h0);

    // R11: count write while running
    @(negedge clk);
    wr(4'h4, 32'd50);
    wr(4'h0, 32'h2);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd(4'h4, v); chk("R11 running", v, 32'd45);
    @(negedge clk);
    wr(4'h4, 32'd20);
    rd(4'h4, v); chk("R11 write wins", v, 32'd20);
    @(posedge clk); @(negedge clk);
    rd(4'h4, v); chk("R11 continues", v, 32'd19);
    @(negedge clk);
    wr(4'h0, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule